// File: doc/BRIEF.md
# Dual Cascadable Baud-Rate Generator

This block holds two 16-bit clock-divider channels, A and B, that run independently of each other. Each channel counts ticks from one of three clock-enable inputs and produces a square wave. Its counter is loaded with the divisor, drops by two on every selected tick, and on the tick that finds it at 2 it reloads and inverts the output. The result has a 50% duty cycle and a frequency of the tick rate divided by the divisor. A run bit in each channel's mode register gates the channel. A timer bit turns the channel into a one-shot: it produces one output period, sets a sticky expiry flag and stops.

Channel B can take its ticks from rising edges of channel A's output instead of an input. The two divisors then multiply. Either channel's output can drive the shared receive clock, the shared transmit clock and its own output pin. When both channels claim a shared clock, channel A has priority.

Software programs the block through a plain single-cycle write port with a 2-bit address. The block has no streaming data path, so no port uses a valid/ready handshake. Every input is taken in the cycle it is presented.

Top module: `dual_brg`

## Requirements
- R1: With the run bit set and an even divisor d >= 2, a channel's output in `brg_out` reads 0 right after its mode write. It then inverts on every (d/2)-th selected tick, so one full output period is d ticks.
- R2: A divisor write (address 0 for A, address 1 for B) made while the channel runs does not shorten or lengthen the half-period in progress. The new value first applies at the following reload.
- R3: A divisor of 0 or 1 behaves as 2. An odd divisor behaves as the next lower even value.
- R4: Mode bits [3:2] select the tick source: 0 `sys_tick`, 1 `xtal_tick`, 2 `ext_tick`. Code 3 selects rising edges of channel A's output for channel B, and gives no ticks at all for channel A. Ticks on the unselected inputs have no effect.
- R5: With mode bit 0 (run) clear, the channel holds its output at 0 and counts nothing. Setting the bit through a mode write starts a fresh full count.
- R6: With mode bit 1 (timer) set, the output goes high after d/2 ticks and back low after d ticks. On that same tick `tmr_done` for the channel sets. After that the flag stays set and the output stays low, whatever ticks arrive, until the channel's mode register (address 2 for A, 3 for B) is written.
- R7: In cascade (channel B, source code 3), channel B advances exactly once per rising edge of channel A's output. The combined output period is dA*dB ticks of channel A's source.
- R8: Mode bit 4 routes a channel to `rx_clk`, bit 5 to `tx_clk`, and bit 6 enables its pin (`pin_out[0]` for A, `pin_out[1]` for B). When both channels claim a shared clock, A drives it. An unclaimed clock or a disabled pin reads 0.
- R9: Writes and ticks aimed at one channel leave the other channel's output unchanged.
- R10: After reset both divisors read as 0 (so they behave as 2), both modes are 0, and all outputs and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 divisor A, 1 divisor B, 2 mode A, 3 mode B |
| wr_data | input | 16 | Write data; mode uses bits [6:0] |
| sys_tick | input | 1 | System clock enable |
| xtal_tick | input | 1 | Crystal clock enable |
| ext_tick | input | 1 | External clock enable |
| brg_out | output | 2 | Square-wave output of channel A [0] and channel B [1] |
| rx_clk | output | 1 | Routed receive clock |
| tx_clk | output | 1 | Routed transmit clock |
| pin_out | output | 2 | Per-channel external pin drive |
| tmr_done | output | 2 | Sticky timer-expiry flags, A [0] and B [1] |

## Verification
The assertions take the tick inputs to be single-cycle enables. They also assume that software re-arms a channel only through its own mode address, so an expired timer may stay quiet until that exact address is written. Within these assumptions, a channel output changes only on a tick or a write, and channel B ticks only on an input or on a fresh rising edge of channel A. The stimulus raises each tick for one cycle and then leaves an idle cycle, so a cascaded channel B always sees channel A's edge before the next tick arrives. All register access goes through single-cycle writes to the four defined addresses.

// File: rtl/dual_brg_pkg.sv
package dual_brg_pkg;
  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_CASC = 2'd3
  } src_e;

  // Packed from MSB: pin_en [6], tx_en [5], rx_en [4], src [3:2], timer [1], run [0]
  typedef struct packed {
    logic pin_en;
    logic tx_en;
    logic rx_en;
    src_e src;
    logic timer;
    logic run;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/brg_src_sel.sv
module brg_src_sel
  import dual_brg_pkg::*;
#(
  parameter bit ALLOW_CASC = 1'b0
) (
  input  src_e src,
  input  logic sys_tick,
  input  logic xtal_tick,
  input  logic ext_tick,
  input  logic casc_rise,
  output logic tick
);
  always_comb begin
    unique case (src)
      SRC_SYS:  tick = sys_tick;
      SRC_XTAL: tick = xtal_tick;
      SRC_EXT:  tick = ext_tick;
      default:  tick = ALLOW_CASC && casc_rise;
    endcase
  end
endmodule

// File: rtl/brg_channel.sv
module brg_channel
  import dual_brg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic             mode_wr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             tick,
  output logic             out,
  output logic             done,
  output src_e             src,
  output logic [2:0]       route   // {pin_en, tx_en, rx_en}
);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  logic [DIV_W-1:0] div_q, cnt_q, eff_div;
  mode_t            mode_q;
  logic             out_q, done_q;

  // Values below 2 act as 2; odd values drop to the even value below
  assign eff_div = (div_q < TWO) ? TWO : {div_q[DIV_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= '0;
      cnt_q  <= TWO;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (div_wr) div_q <= wr_data;
      if (mode_wr) begin
        mode_q <= mode_t'(wr_data[MODE_W-1:0]);
        cnt_q  <= eff_div;
        out_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (!mode_q.run) begin
        cnt_q <= eff_div;
        out_q <= 1'b0;
      end else if (tick && !done_q) begin
        if (cnt_q <= TWO) begin
          cnt_q <= eff_div;
          out_q <= ~out_q;
          if (mode_q.timer && out_q) done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - TWO;
        end
      end
    end
  end

  assign out   = out_q;
  assign done  = done_q;
  assign src   = mode_q.src;
  assign route = {mode_q.pin_en, mode_q.tx_en, mode_q.rx_en};
endmodule

// File: rtl/brg_route.sv
module brg_route #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] ch_out,
  input  logic [NCH-1:0] rx_en,
  input  logic [NCH-1:0] tx_en,
  input  logic [NCH-1:0] pin_en,
  output logic           rx_clk,
  output logic           tx_clk,
  output logic [NCH-1:0] pin_out
);
  // Lowest channel index wins a shared clock
  always_comb begin
    rx_clk = 1'b0;
    tx_clk = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rx_en[i]) rx_clk = ch_out[i];
      if (tx_en[i]) tx_clk = ch_out[i];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pin_out[i] = pin_en[i] & ch_out[i];
  end
endmodule

// File: rtl/dual_brg.sv
module dual_brg
  import dual_brg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             sys_tick,
  input  logic             xtal_tick,
  input  logic             ext_tick,
  output logic [1:0]       brg_out,
  output logic             rx_clk,
  output logic             tx_clk,
  output logic [1:0]       pin_out,
  output logic [1:0]       tmr_done
);
  localparam int NCH = 2;

  logic [NCH-1:0] ch_tick, rx_en, tx_en, pin_en;
  logic           a_prev_q, a_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) a_prev_q <= 1'b0;
    else        a_prev_q <= brg_out[0];
  end
  assign a_rise = brg_out[0] & ~a_prev_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    src_e       src;
    logic [2:0] route;

    brg_src_sel #(.ALLOW_CASC(c != 0)) u_sel (
      .src(src), .sys_tick(sys_tick), .xtal_tick(xtal_tick),
      .ext_tick(ext_tick), .casc_rise(a_rise), .tick(ch_tick[c])
    );

    brg_channel #(.DIV_W(DIV_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .div_wr(wr_en && (wr_addr == 2'(c))),
      .mode_wr(wr_en && (wr_addr == 2'(c + 2))),
      .wr_data(wr_data), .tick(ch_tick[c]),
      .out(brg_out[c]), .done(tmr_done[c]), .src(src), .route(route)
    );

    assign rx_en[c]  = route[0];
    assign tx_en[c]  = route[1];
    assign pin_en[c] = route[2];
  end

  brg_route #(.NCH(NCH)) u_route (
    .ch_out(brg_out), .rx_en(rx_en), .tx_en(tx_en), .pin_en(pin_en),
    .rx_clk(rx_clk), .tx_clk(tx_clk), .pin_out(pin_out)
  );
endmodule

// File: rtl/dual_brg_chk.sv
module dual_brg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       sys_tick,
  input logic       xtal_tick,
  input logic       ext_tick,
  input logic [1:0] ch_tick,
  input logic [1:0] brg_out,
  input logic       rx_clk,
  input logic [1:0] pin_out,
  input logic [1:0] tmr_done
);
  for (genvar i = 0; i < 2; i++) begin : g_c
    // R1: the output moves only on a tick or a register write
    p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_tick[i] && !wr_en) |=> $stable(brg_out[i]));
    // R6: expiry flag is sticky until the own mode address is written
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_done[i] && !(wr_en && wr_addr == 2'(i + 2))) |=> (tmr_done[i] && !brg_out[i]));
    // R6: expiry coincides with the falling output edge
    p_done_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_done[i]) |-> $fell(brg_out[i]));
    // R8: an enabled pin never shows a level the channel does not have
    p_pin_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out[i] |-> brg_out[i]);
  end

  // R7: channel B only steps on an input tick or a fresh rising edge of A
  p_cascade_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tick[1] |-> (sys_tick || xtal_tick || ext_tick || $rose(brg_out[0])));

  // R8: receive clock high needs a high channel output
  p_rx_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk |-> (brg_out != 2'b00));
endmodule

bind dual_brg dual_brg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sys_tick(sys_tick), .xtal_tick(xtal_tick), .ext_tick(ext_tick),
  .ch_tick(ch_tick), .brg_out(brg_out), .rx_clk(rx_clk),
  .pin_out(pin_out), .tmr_done(tmr_done)
);

// File: tb/dual_brg_test.sv
module dual_brg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] T_SYS = 3'b001, T_XTAL = 3'b010, T_EXT = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sys_tick = 1'b0, xtal_tick = 1'b0, ext_tick = 1'b0;
  logic [1:0]  brg_out, pin_out, tmr_done;
  logic        rx_clk, tx_clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_brg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_tick(sys_tick), .xtal_tick(xtal_tick), .ext_tick(ext_tick),
    .brg_out(brg_out), .rx_clk(rx_clk), .tx_clk(tx_clk),
    .pin_out(pin_out), .tmr_done(tmr_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One-cycle tick on the chosen inputs, then an idle cycle
  task automatic pulse(input logic [2:0] s);
    @(negedge clk);
    {ext_tick, xtal_tick, sys_tick} = s;
    @(negedge clk);
    {ext_tick, xtal_tick, sys_tick} = 3'b000;
    @(negedge clk);
  endtask

  function automatic int eff(input int d);
    return (d < 2) ? 2 : (d & ~1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 brg_out", brg_out, 0);
    chk("R10 tmr_done", tmr_done, 0);
    chk("R10 rx/tx", {rx_clk, tx_clk}, 0);
    chk("R10 pin_out", pin_out, 0);

    // R1 / R3 sweep of channel A divisors 0..13 on sys_tick
    for (int d = 0; d < 14; d++) begin
      int h;
      h = eff(d) / 2;
      wr(2'd0, 16'(d));
      wr(2'd2, 16'h0001);
      chk("R1 armed low", brg_out[0], 0);
      for (int k = 1; k <= 3 * eff(d); k++) begin
        pulse(T_SYS);
        chk((d < 2 || d % 2) ? "R3 divisor rounding" : "R1 half-period", brg_out[0], (k / h) % 2);
      end
    end

    // R9 / R4 channel B sweep on xtal_tick while A waits for sys_tick
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0001);
    for (int d = 2; d < 10; d++) begin
      int h;
      h = eff(d) / 2;
      wr(2'd1, 16'(d));
      wr(2'd3, 16'h0005);
      for (int k = 1; k <= 2 * eff(d); k++) begin
        pulse(T_XTAL);
        chk("R4 channel B xtal", brg_out[1], (k / h) % 2);
        chk("R9 channel A untouched", brg_out[0], 0);
      end
    end
    wr(2'd3, 16'h0000);

    // R4 source selection on channel A
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0005);
    for (int k = 0; k < 4; k++) pulse(T_SYS | T_EXT);
    chk("R4 unselected ticks ignored", brg_out[0], 0);
    pulse(T_XTAL); pulse(T_XTAL);
    chk("R4 xtal selected", brg_out[0], 1);
    wr(2'd2, 16'h0009);
    pulse(T_EXT); pulse(T_EXT);
    pulse(T_XTAL); pulse(T_XTAL); pulse(T_SYS);
    chk("R4 ext selected", brg_out[0], 1);
    wr(2'd2, 16'h000D);
    for (int k = 0; k < 4; k++) pulse(T_SYS | T_XTAL | T_EXT);
    chk("R4 code 3 on A gives no ticks", brg_out[0], 0);

    // R5 gate
    wr(2'd2, 16'h0000);
    for (int k = 0; k < 6; k++) pulse(T_SYS);
    chk("R5 gated off", brg_out[0], 0);
    wr(2'd2, 16'h0001);
    pulse(T_SYS);
    chk("R5 fresh count", brg_out[0], 0);
    pulse(T_SYS);
    chk("R5 runs after gate", brg_out[0], 1);

    // R2 divisor change applies at the next reload
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0001);
    pulse(T_SYS);
    wr(2'd0, 16'd8);
    pulse(T_SYS);
    chk("R2 old half-period finishes", brg_out[0], 1);
    for (int k = 0; k < 3; k++) pulse(T_SYS);
    chk("R2 new half-period not done", brg_out[0], 1);
    pulse(T_SYS);
    chk("R2 new half-period done", brg_out[0], 0);

    // R6 timer one-shot, d = 6
    wr(2'd0, 16'd6);
    wr(2'd2, 16'h0003);
    pulse(T_SYS); pulse(T_SYS);
    chk("R6 timer low", brg_out[0], 0);
    pulse(T_SYS);
    chk("R6 timer high", brg_out[0], 1);
    chk("R6 not yet expired", tmr_done[0], 0);
    pulse(T_SYS); pulse(T_SYS); pulse(T_SYS);
    chk("R6 timer back low", brg_out[0], 0);
    chk("R6 expired", tmr_done[0], 1);
    for (int k = 0; k < 10; k++) pulse(T_SYS);
    chk("R6 stays stopped", brg_out[0], 0);
    chk("R6 flag sticky", tmr_done[0], 1);
    wr(2'd1, 16'd2);
    chk("R6 other address keeps flag", tmr_done[0], 1);
    wr(2'd2, 16'h0003);
    chk("R6 re-armed", tmr_done[0], 0);
    pulse(T_SYS); pulse(T_SYS); pulse(T_SYS);
    chk("R6 re-armed runs", brg_out[0], 1);

    // R7 cascade: A d=4 on sys, B d=6 on A's rising edges
    wr(2'd1, 16'd6);
    wr(2'd3, 16'h000D);
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0001);
    for (int k = 1; k <= 48; k++) begin
      pulse(T_SYS);
      chk("R7 cascade", brg_out[1], (((k + 2) / 4) / 3) % 2);
    end
    wr(2'd3, 16'h0000);

    // R8 routing and priority
    wr(2'd0, 16'd2);
    wr(2'd2, 16'h0051);
    wr(2'd1, 16'd8);
    wr(2'd3, 16'h0031);
    pulse(T_SYS);
    chk("R8 rx from A", rx_clk, 1);
    chk("R8 tx from B", tx_clk, 0);
    chk("R8 pins", pin_out, 1);
    pulse(T_SYS);
    chk("R8 rx follows A low", rx_clk, 0);
    wr(2'd2, 16'h0001);
    pulse(T_SYS); pulse(T_SYS);
    chk("R8 rx falls to B", rx_clk, 1);
    chk("R8 tx from B high", tx_clk, 1);
    chk("R8 pins disabled", pin_out, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule